// File: doc/BRIEF.md
# Bubble-Collapsing Elastic Shift Pipeline

This block is a chain of storage stages that carries data words from a producer to a consumer using valid/ready handshakes. Each stage holds one word and a flag that marks the slot as occupied. A word moves one stage toward the output only when the stage ahead of it is free at the next clock edge. That happens when the consumer is taking the head word, or when some stage nearer the output is empty.

Because of this rule, empty slots left by a producer that idles between words do not travel through the pipe. They are closed up while the consumer stalls, so the pipe can fill completely before it pushes back on the producer. The number of stages and the word width are parameters. The producer sees a single combinational ready signal, which is high whenever the first stage can load.

Top module: `bubble_squeeze_pipe`

## Requirements
- R1: A synchronous reset marks every stage empty. After reset `outValid` is 0 and `inReady` is 1, even if words were held before the reset.
- R2: Words leave on handshakes (`outValid` and `outReady` both 1) in the order they were accepted (`inValid` and `inReady` both 1), with none lost and none repeated. While `outValid` is 1 and `outReady` is 0, `outData` holds its value.
- R3: While `outReady` is 1, `inReady` is 1 whatever the occupancy.
- R4: While `outReady` is 0, `inReady` is 1 whenever fewer than STAGES words are held. Empty slots are squeezed out instead of blocking intake.
- R5: `inReady` is 0 exactly when all STAGES slots hold words and `outReady` is 0.
- R6: A word accepted into an empty pipe is presented on `outValid`/`outData` after STAGES clock edges, counting the accepting edge. This holds whether or not `outReady` is high.
- R7: Each clock edge, every held word moves one stage toward the output if `outReady` is 1 or if, counting from just past its own stage, the stages up to the output hold fewer words than that span has slots. Otherwise it stays where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Producer offers `inData` this cycle |
| inData | input | DATA_W | Word offered by the producer |
| inReady | output | 1 | First stage can load this cycle |
| outValid | output | 1 | Last stage holds a word |
| outData | output | DATA_W | Word in the last stage |
| outReady | input | 1 | Consumer takes the head word this cycle |

## Verification
The bench targets the following cases:
- **A lone word entering an empty pipe while the consumer stalls.** A design that carried gaps along, or that needed ready to shift, would never present the word or would present it late.
- **Filling with the consumer held off, including trains with gaps.** This shows whether intake stops exactly at full occupancy. A design with a wrong enable chain would either overwrite a held word or refuse input while a hole remains.
- **Long random runs of producer idles and consumer stalls.** These are compared cycle by cycle against a queue model of word positions. They expose reordering, duplication from stages loading without their word moving on, and head data changing during a stall.
- **A reset while the pipe is full.** A design that cleared only part of the state would leave stale words behind.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  // Per-stage strobes sent from control to the datapath.
  typedef struct packed {
    logic advance;   // stage loads from its upstream neighbour this edge
    logic srcValid;  // the upstream neighbour holds a real word
  } stageStrobe_t;

endpackage

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
  import bsp_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic                        outReady,
  output logic                        outValid,
  output stageStrobe_t [STAGES-1:0]   strobe
);

  logic [STAGES-1:0] validQ;
  logic [STAGES-1:0] slotEn;
  logic [STAGES-1:0] srcValid;

  // Suffix OR from the output side: a stage may load when the consumer
  // takes the head or any stage at or beyond it is empty.
  always_comb begin
    logic acc;
    acc = outReady;
    for (int k = STAGES - 1; k >= 0; k--) begin
      acc       = acc | ~validQ[k];
      slotEn[k] = acc;
    end
  end

  always_comb begin
    srcValid[0] = inValid;
    for (int k = 1; k < STAGES; k++) srcValid[k] = validQ[k-1];
  end

  always_comb begin
    for (int k = 0; k < STAGES; k++) begin
      strobe[k].advance  = slotEn[k];
      strobe[k].srcValid = srcValid[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++)
        if (slotEn[k]) validQ[k] <= srcValid[k];
    end
  end

  assign inReady  = slotEn[0];
  assign outValid = validQ[STAGES-1];

  // R3: a consumer taking the head frees room all the way to the input.
  p_out_ready_admits_r3: assert property (@(posedge clk) disable iff (rst)
    outReady |-> inReady);

endmodule

// File: rtl/bsp_data.sv
module bsp_data
  import bsp_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int DATA_W = 200
) (
  input  logic                        clk,
  input  logic [DATA_W-1:0]           inData,
  input  stageStrobe_t [STAGES-1:0]   strobe,
  output logic [DATA_W-1:0]           outData
);

  logic [DATA_W-1:0] dataQ [STAGES];

  // Data registers load only when a real word arrives, so bubbles
  // cause no toggling in the wide datapath.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk)
        if (strobe[g].advance & strobe[g].srcValid) dataQ[g] <= inData;
    end else begin : g_body
      always_ff @(posedge clk)
        if (strobe[g].advance & strobe[g].srcValid) dataQ[g] <= dataQ[g-1];
    end
  end

  assign outData = dataQ[STAGES-1];

endmodule

// File: rtl/bubble_squeeze_pipe.sv
module bubble_squeeze_pipe
  import bsp_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int DATA_W = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);

  localparam int OCC_W = $clog2(STAGES + 1) + 1;

  stageStrobe_t [STAGES-1:0] strobe;

  bsp_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  bsp_data #(.STAGES(STAGES), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .inData  (inData),
    .strobe  (strobe),
    .outData (outData)
  );

  // Checking logic: occupancy seen only through the handshakes.
  logic [OCC_W-1:0] occQ;
  logic inTake, outTake;
  assign inTake  = inValid & inReady;
  assign outTake = outValid & outReady;

  always_ff @(posedge clk) begin
    if (rst) occQ <= '0;
    else begin
      case ({inTake, outTake})
        2'b10:   occQ <= occQ + 1'b1;
        2'b01:   occQ <= occQ - 1'b1;
        default: occQ <= occQ;
      endcase
    end
  end

  // R2: never more words held than slots exist.
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
    int'(occQ) <= STAGES);

  // R2: a stalled head keeps its word and value.
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R1: an empty pipe shows nothing at the output.
  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (occQ == '0) |-> !outValid);

  // R4: any free slot admits input, even under a stall.
  p_gap_admits_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(occQ) < STAGES) |-> inReady);

  // R5: full and stalled means back-pressure.
  p_full_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    ((int'(occQ) == STAGES) && !outReady) |-> !inReady);

endmodule

// File: tb/bubble_squeeze_pipe_bench.sv
`timescale 1ns/1ps
module bubble_squeeze_pipe_bench;

  localparam int N  = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic [DW-1:0] inData;
  logic          inReady;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          outReady;

  always #2 clk = ~clk;

  bubble_squeeze_pipe #(.STAGES(N), .DATA_W(DW)) u_bubble_squeeze_pipe (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady)
  );

  int compared   = 0;
  int mismatched = 0;

  // Reference model: words with their stage position, head first.
  int            mPos[$];
  logic [DW-1:0] mDat[$];
  logic [DW-1:0] seqVal = 16'h1000;
  string         vTag = "R2";

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Word i moves when the consumer is ready, or when the stages past it
  // hold fewer words than that span has slots.
  task automatic modelStep(input logic v, input logic r);
    int            np[$];
    logic [DW-1:0] nd[$];
    logic          admit;
    admit = r || (mPos.size() < N);
    for (int i = 0; i < mPos.size(); i++) begin
      if (i == 0 && mPos[0] == N - 1 && r) continue;
      if (r || ((N - 1 - mPos[i]) > i)) np.push_back(mPos[i] + 1);
      else np.push_back(mPos[i]);
      nd.push_back(mDat[i]);
    end
    if (v && admit) begin
      np.push_back(0);
      nd.push_back(inData);
    end
    mPos = np;
    mDat = nd;
  endtask

  task automatic cycle(input logic v, input logic r);
    logic expV;
    logic expRdy;
    @(negedge clk);
    expV = (mPos.size() > 0) && (mPos[0] == N - 1);
    check({vTag, " outValid"}, DW'(outValid), DW'(expV));
    if (expV) check("R2 outData", outData, mDat[0]);
    inValid  = v;
    outReady = r;
    if (v) begin
      inData = seqVal;
    end else begin
      inData = 16'hDEAD;
    end
    #1;
    expRdy = r || (mPos.size() < N);
    if (r)                  check("R3 inReady", DW'(inReady), DW'(expRdy));
    else if (mPos.size() < N) check("R4 inReady", DW'(inReady), DW'(expRdy));
    else                    check("R5 inReady", DW'(inReady), DW'(expRdy));
    if (v && expRdy) seqVal = seqVal + 1'b1;
    modelStep(v, r);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; outReady = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mPos.delete();
    mDat.delete();
    #1;
    check("R1 outValid after reset", DW'(outValid), DW'(0));
    check("R1 inReady after reset", DW'(inReady), DW'(1));
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inData = '0; outReady = 1'b0;
    doReset();

    // R6: lone word into empty pipe, consumer stalled, then drained.
    vTag = "R6";
    cycle(1'b1, 1'b0);
    for (int i = 0; i < N + 2; i++) cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b1);
    cycle(1'b1, 1'b1);
    for (int i = 0; i < N + 1; i++) cycle(1'b0, 1'b1);

    // R5: fill solid while stalled, then R3 stream through.
    vTag = "R2";
    for (int i = 0; i < N + 3; i++) cycle(1'b1, 1'b0);
    for (int i = 0; i < 3 * N; i++) cycle(1'b1, 1'b1);
    for (int i = 0; i < N + 1; i++) cycle(1'b0, 1'b1);

    // R4, R7: gapped train under stall gets squeezed together.
    vTag = "R7";
    for (int i = 0; i < 3 * N; i++) cycle(i % 3 == 0, 1'b0);
    for (int i = 0; i < 2 * N; i++) cycle(1'b0, i % 2 == 0);

    // R2: random producer idles and consumer stalls.
    vTag = "R2";
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 10) < 6, ($urandom % 2) == 0);

    // R1: reset with the pipe full.
    for (int i = 0; i < N + 2; i++) cycle(1'b1, 1'b0);
    doReset();
    vTag = "R1";
    for (int i = 0; i < N + 1; i++) cycle(1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule